// File: doc/BRIEF.md
# NOR Flash Program and Erase Sequencer

This controller sits on the host side of a parallel NOR flash bus. It turns a single request into a complete embedded-algorithm transaction. A request carries an operation (byte program or chip erase), a target address and a data byte, and it is accepted through a valid/ready handshake. The controller then writes the two-cycle unlock preamble and the command bytes the operation needs. For a program request it writes the data byte to its target last.

After the final command write, the controller reads the target location over and over. It watches bit 7 of the returned byte until that bit shows the operation has finished. It then reports completion with a one-cycle done pulse.

If the device never reports completion within a set number of reads, the controller writes the reset command and reports an error instead.

The strobe timing is fixed by parameters counted in clock cycles:
- address setup before write-enable falls,
- write-enable low width,
- hold after write-enable rises,
- read access time.

Chip-enable returns high for at least one clock between bus cycles.

Top module: `nor_flash_seq`

## Requirements
- R1: `req_ready_o` is high only while idle. It goes low in the cycle after a request is accepted (`req_valid_i` and `req_ready_o` both high at a clock edge). It stays low until the cycle after the `done_o` pulse.
- R2: A program request (`req_erase_i`=0) issues exactly four write cycles, in this order: 0x555/0xAA, 0x2AA/0x55, 0x555/0xA0, then the request address with the request data.
- R3: An erase request (`req_erase_i`=1) issues exactly six write cycles, in this order: 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, 0x555/0x10.
- R4: The write strobe obeys these rules:
  - Write-enable is low for exactly PULSE_CLK clocks.
  - Chip-enable is low whenever write-enable is low.
  - The address is already stable in the clock before write-enable falls and does not change while it is low.
  - The data is driven and unchanged through the rising edge of write-enable.
  - Output-enable and write-enable are never low together.
- R5: After a program, the controller reads the request address until DQ bit 7 equals bit 7 of the written data. It then pulses `done_o` with `err_o`=0. The number of reads is one more than the number of busy responses.
- R6: After an erase, the controller reads until DQ bit 7 reads 1. It then pulses `done_o` with `err_o`=0.
- R7: If POLL_LIMIT consecutive reads all fail to match, the controller writes 0xF0 to address 0 and then pulses `done_o` with `err_o`=1.
- R8: Program requests may use any address, in any order.
- R9: After reset, the outputs are: `req_ready_o`=1, `done_o`=0, `err_o`=0, all strobes high, and the data bus not driven.
- R10: `err_o` is high only in a cycle where `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle, can accept a request |
| req_erase_i | input | 1 | 1 = chip erase, 0 = byte program |
| req_addr_i | input | AW | Target address |
| req_data_i | input | 8 | Byte to program |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Poll timeout, valid with done_o |
| flash_addr_o | output | AW | Flash address bus |
| flash_dq_o | output | 8 | Write data to flash |
| flash_dq_oe_o | output | 1 | Drive enable for the data bus |
| flash_dq_i | input | 8 | Read data from flash |
| flash_ce_no | output | 1 | Chip enable, active low |
| flash_we_no | output | 1 | Write enable, active low |
| flash_oe_no | output | 1 | Output enable, active low |

## Verification
The bench builds the block with these parameters:
- AW=11, the smallest width that still holds the unlock addresses;
- one-clock setup and hold;
- a two-clock write pulse and a two-clock read;
- POLL_LIMIT=4.

With these values, the bench sweeps every one of the 256 program data bytes, so both values of the polled bit occur at scattered addresses. For each request it also varies the number of busy poll responses from zero up to one below the limit.

The small limit makes the timeout path cheap to reach for both operations. It also places the last-chance successful poll next to the first failing case.

// File: rtl/nor_flash_seq_pkg.sv
package nor_flash_seq_pkg;
  typedef enum logic [2:0] {S_IDLE, S_CMD, S_POLL, S_ABORT, S_RESP} seq_state_e;
  typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD, PH_READ} bus_phase_e;
  localparam logic [10:0] UNLOCK_A = 11'h555;
  localparam logic [10:0] UNLOCK_B = 11'h2AA;
  localparam logic [7:0]  KEY_A    = 8'hAA;
  localparam logic [7:0]  KEY_B    = 8'h55;
  localparam logic [7:0]  CMD_PROG = 8'hA0;
  localparam logic [7:0]  CMD_ERSU = 8'h80;
  localparam logic [7:0]  CMD_CHIP = 8'h10;
  localparam logic [7:0]  CMD_RST  = 8'hF0;
endpackage

// File: rtl/nor_cmd_rom.sv
module nor_cmd_rom
  import nor_flash_seq_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          erase_i,
  input  logic [2:0]    idx_i,
  input  logic [AW-1:0] tgt_addr_i,
  input  logic [7:0]    tgt_data_i,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    data_o,
  output logic          last_o
);
  always_comb begin
    addr_o = AW'(UNLOCK_A);
    data_o = KEY_A;
    case (idx_i)
      3'd1, 3'd4: begin
        addr_o = AW'(UNLOCK_B);
        data_o = KEY_B;
      end
      3'd2: data_o = erase_i ? CMD_ERSU : CMD_PROG;
      3'd3: if (!erase_i) begin
        addr_o = tgt_addr_i;
        data_o = tgt_data_i;
      end
      3'd5: data_o = CMD_CHIP;
      default: ;
    endcase
  end

  assign last_o = erase_i ? (idx_i == 3'd5) : (idx_i == 3'd3);
endmodule

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle
  import nor_flash_seq_pkg::*;
#(
  parameter int AW        = 20,
  parameter int SETUP_CLK = 2,
  parameter int PULSE_CLK = 4,
  parameter int HOLD_CLK  = 1,
  parameter int READ_CLK  = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          idle_o,
  output logic          done_o,
  output logic          rd_d7_o,
  output logic [AW-1:0] flash_addr_o,
  output logic [7:0]    flash_dq_o,
  output logic          flash_dq_oe_o,
  input  logic          flash_d7_i,
  output logic          flash_ce_no,
  output logic          flash_we_no,
  output logic          flash_oe_no
);
  localparam int M1 = SETUP_CLK > PULSE_CLK ? SETUP_CLK : PULSE_CLK;
  localparam int M2 = HOLD_CLK > READ_CLK ? HOLD_CLK : READ_CLK;
  localparam int MAXC = M1 > M2 ? M1 : M2;
  localparam int CW = $clog2(MAXC + 1);

  bus_phase_e    phase_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic          wr_q;
  int            len;
  logic          last;

  always_comb begin
    case (phase_q)
      PH_SETUP: len = SETUP_CLK;
      PH_PULSE: len = PULSE_CLK;
      PH_HOLD:  len = HOLD_CLK;
      PH_READ:  len = READ_CLK;
      default:  len = 1;
    endcase
  end
  assign last = (cnt_q == CW'(len - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      wr_q    <= 1'b0;
    end else if (phase_q == PH_IDLE) begin
      if (start_i) begin
        phase_q <= wr_i ? PH_SETUP : PH_READ;
        cnt_q   <= '0;
        addr_q  <= addr_i;
        data_q  <= data_i;
        wr_q    <= wr_i;
      end
    end else if (last) begin
      cnt_q <= '0;
      case (phase_q)
        PH_SETUP: phase_q <= PH_PULSE;
        PH_PULSE: phase_q <= PH_HOLD;
        default:  phase_q <= PH_IDLE;
      endcase
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign idle_o        = (phase_q == PH_IDLE);
  assign done_o        = last && (phase_q == PH_HOLD || phase_q == PH_READ);
  assign rd_d7_o       = flash_d7_i;
  assign flash_addr_o  = addr_q;
  assign flash_dq_o    = data_q;
  assign flash_dq_oe_o = wr_q && phase_q != PH_IDLE && phase_q != PH_READ;
  assign flash_ce_no   = (phase_q == PH_IDLE);
  assign flash_we_no   = (phase_q != PH_PULSE);
  assign flash_oe_no   = (phase_q != PH_READ);
endmodule

// File: rtl/nor_flash_seq.sv
module nor_flash_seq
  import nor_flash_seq_pkg::*;
#(
  parameter int AW         = 20,
  parameter int SETUP_CLK  = 2,
  parameter int PULSE_CLK  = 4,
  parameter int HOLD_CLK   = 1,
  parameter int READ_CLK   = 3,
  parameter int POLL_LIMIT = 4096
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_erase_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [7:0]    req_data_i,
  output logic          done_o,
  output logic          err_o,
  output logic [AW-1:0] flash_addr_o,
  output logic [7:0]    flash_dq_o,
  output logic          flash_dq_oe_o,
  input  logic [7:0]    flash_dq_i,
  output logic          flash_ce_no,
  output logic          flash_we_no,
  output logic          flash_oe_no
);
  localparam int PW = $clog2(POLL_LIMIT + 1);

  seq_state_e    state_q;
  logic          erase_q, err_q;
  logic [AW-1:0] tgt_addr_q;
  logic [7:0]    tgt_data_q;
  logic [2:0]    idx_q;
  logic [PW-1:0] poll_q;

  logic [AW-1:0] rom_addr, bus_addr;
  logic [7:0]    rom_data, bus_data;
  logic          rom_last, bus_wr, bus_start, bus_idle, bus_done, rd_d7, poll_hit;
  logic [6:0]    dq_low_unused;

  assign dq_low_unused = flash_dq_i[6:0];

  nor_cmd_rom #(.AW(AW)) u_rom (
    .erase_i(erase_q), .idx_i(idx_q), .tgt_addr_i(tgt_addr_q), .tgt_data_i(tgt_data_q),
    .addr_o(rom_addr), .data_o(rom_data), .last_o(rom_last)
  );

  always_comb begin
    bus_wr   = 1'b1;
    bus_addr = rom_addr;
    bus_data = rom_data;
    if (state_q == S_POLL) begin
      bus_wr   = 1'b0;
      bus_addr = tgt_addr_q;
      bus_data = '0;
    end else if (state_q == S_ABORT) begin
      bus_addr = '0;
      bus_data = CMD_RST;
    end
  end

  assign bus_start = bus_idle && (state_q == S_CMD || state_q == S_POLL || state_q == S_ABORT);
  assign poll_hit  = rd_d7 == (erase_q ? 1'b1 : tgt_data_q[7]);

  nor_bus_cycle #(
    .AW(AW), .SETUP_CLK(SETUP_CLK), .PULSE_CLK(PULSE_CLK),
    .HOLD_CLK(HOLD_CLK), .READ_CLK(READ_CLK)
  ) u_bus (
    .clk_i, .rst_ni,
    .start_i(bus_start), .wr_i(bus_wr), .addr_i(bus_addr), .data_i(bus_data),
    .idle_o(bus_idle), .done_o(bus_done), .rd_d7_o(rd_d7),
    .flash_addr_o, .flash_dq_o, .flash_dq_oe_o,
    .flash_d7_i(flash_dq_i[7]),
    .flash_ce_no, .flash_we_no, .flash_oe_no
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      erase_q    <= 1'b0;
      err_q      <= 1'b0;
      tgt_addr_q <= '0;
      tgt_data_q <= '0;
      idx_q      <= '0;
      poll_q     <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid_i) begin
          state_q    <= S_CMD;
          erase_q    <= req_erase_i;
          tgt_addr_q <= req_addr_i;
          tgt_data_q <= req_data_i;
          idx_q      <= '0;
          poll_q     <= '0;
          err_q      <= 1'b0;
        end
        S_CMD: if (bus_done) begin
          if (rom_last) state_q <= S_POLL;
          else          idx_q   <= idx_q + 1'b1;
        end
        S_POLL: if (bus_done) begin
          if (poll_hit)                              state_q <= S_RESP;
          else if (poll_q == PW'(POLL_LIMIT - 1))    state_q <= S_ABORT;
          else                                       poll_q  <= poll_q + 1'b1;
        end
        S_ABORT: if (bus_done) begin
          err_q   <= 1'b1;
          state_q <= S_RESP;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign done_o      = (state_q == S_RESP);
  assign err_o       = done_o && err_q;
endmodule

// File: rtl/nor_flash_seq_chk.sv
module nor_flash_seq_chk #(
  parameter int AW = 20
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          done_o,
  input logic          err_o,
  input logic [AW-1:0] flash_addr_o,
  input logic [7:0]    flash_dq_o,
  input logic          flash_dq_oe_o,
  input logic          flash_ce_no,
  input logic          flash_we_no,
  input logic          flash_oe_no
);
  // R1
  accept_drops_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);
  // R1
  ready_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_ready_o) |-> $past(done_o));
  // R4
  we_needs_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_we_no |-> !flash_ce_no);
  // R4
  oe_we_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!flash_we_no && !flash_oe_no));
  // R4
  addr_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flash_we_no) |-> $stable(flash_addr_o) && $stable(flash_dq_o));
  // R4
  addr_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_we_no && $past(!flash_we_no) |-> $stable(flash_addr_o));
  // R4
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flash_we_no) |-> $stable(flash_dq_o) && flash_dq_oe_o && !flash_ce_no);
  // R4
  no_drive_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_oe_no |-> !flash_dq_oe_o);
  // R10
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
endmodule

bind nor_flash_seq nor_flash_seq_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .done_o(done_o), .err_o(err_o), .flash_addr_o(flash_addr_o), .flash_dq_o(flash_dq_o),
  .flash_dq_oe_o(flash_dq_oe_o), .flash_ce_no(flash_ce_no), .flash_we_no(flash_we_no),
  .flash_oe_no(flash_oe_no)
);

// File: tb/nor_flash_seq_test.sv
module nor_flash_seq_test;
  localparam int AW = 11;
  localparam int PULSE = 2;
  localparam int LIMIT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, erase = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] data = '0;
  logic ready, done, err, dq_oe, ce_n, we_n, oe_n;
  logic [AW-1:0] f_addr;
  logic [7:0] f_dq_o, f_dq_i;

  int checks = 0, fails = 0;
  int busy_left = 0;
  logic exp_bit = 1'b0;
  logic [AW-1:0] exp_rd_addr = '0;
  int wr_n = 0, rd_n = 0, rd_bad = 0, t_viol = 0, lo_cnt = 0;
  logic [AW-1:0] wr_a [0:15];
  logic [7:0] wr_d [0:15];
  logic we_p = 1'b1, oe_p = 1'b1, ce_p = 1'b1;
  logic [AW-1:0] a_p = '0, lat_a = '0;
  logic [7:0] lat_d = '0;
  int cycles = 0;

  always #4 clk = ~clk;

  nor_flash_seq #(.AW(AW), .SETUP_CLK(1), .PULSE_CLK(PULSE), .HOLD_CLK(1),
                  .READ_CLK(2), .POLL_LIMIT(LIMIT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_erase_i(erase), .req_addr_i(addr), .req_data_i(data), .done_o(done), .err_o(err),
    .flash_addr_o(f_addr), .flash_dq_o(f_dq_o), .flash_dq_oe_o(dq_oe), .flash_dq_i(f_dq_i),
    .flash_ce_no(ce_n), .flash_we_no(we_n), .flash_oe_no(oe_n)
  );

  // flash model: busy reads return inverted status bit
  assign f_dq_i = (!oe_n && !ce_n) ? (busy_left > 0 ? {~exp_bit, 7'h15} : {exp_bit, 7'h2A}) : 8'hFF;

  always @(negedge clk) begin
    cycles++;
    if (!we_n && !oe_n) t_viol++;
    if (!we_n) begin
      if (we_p) begin
        if (f_addr !== a_p || ce_p || ce_n) t_viol++;
        lo_cnt = 1; lat_a = f_addr; lat_d = f_dq_o;
      end else begin
        lo_cnt++;
        if (f_addr !== lat_a || f_dq_o !== lat_d || ce_n) t_viol++;
      end
    end else if (!we_p) begin
      if (lo_cnt != PULSE || f_dq_o !== lat_d || !dq_oe || ce_n) t_viol++;
      if (wr_n < 16) begin wr_a[wr_n] = lat_a; wr_d[wr_n] = lat_d; end
      wr_n++;
    end
    if (!oe_n && f_addr !== exp_rd_addr) rd_bad++;
    if (oe_n && !oe_p) begin
      rd_n++;
      if (busy_left > 0) busy_left--;
    end
    we_p = we_n; oe_p = oe_n; ce_p = ce_n; a_p = f_addr;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input bit er, input logic [AW-1:0] a, input logic [7:0] d,
                        input int busy, input bit tmo);
    logic [AW-1:0] ea [0:7];
    logic [7:0] ed [0:7];
    int n, cyc;
    bit ok;
    exp_bit = er ? 1'b1 : d[7];
    busy_left = busy; exp_rd_addr = a; wr_n = 0; rd_n = 0; rd_bad = 0;
    ea[0] = 11'h555; ed[0] = 8'hAA; ea[1] = 11'h2AA; ed[1] = 8'h55;
    if (er) begin
      ea[2] = 11'h555; ed[2] = 8'h80; ea[3] = 11'h555; ed[3] = 8'hAA;
      ea[4] = 11'h2AA; ed[4] = 8'h55; ea[5] = 11'h555; ed[5] = 8'h10; n = 6;
    end else begin
      ea[2] = 11'h555; ed[2] = 8'hA0; ea[3] = a; ed[3] = d; n = 4;
    end
    if (tmo) begin ea[n] = '0; ed[n] = 8'hF0; n++; end
    @(negedge clk);
    valid = 1'b1; erase = er; addr = a; data = d;
    @(negedge clk);
    valid = 1'b0;
    chk(ready == 1'b0, "R1 ready low after accept", ready, 0);
    cyc = 0;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    chk(done == 1'b1, "R1 done reached", done, 1);
    if (tmo) chk(err == 1'b1, "R7 timeout error", err, 1);
    else chk(err == 1'b0, er ? "R6 erase ok status" : "R5 program ok status", err, 0);
    @(negedge clk);
    chk(ready == 1'b1 && done == 1'b0 && err == 1'b0, "R1 R10 back to idle", {ready, done, err}, 3'b100);
    ok = (wr_n == n);
    for (int i = 0; i < n && i < 16; i++) if (wr_a[i] !== ea[i] || wr_d[i] !== ed[i]) ok = 0;
    chk(ok, er ? "R3 erase write cycles" : "R2 R8 program write cycles", wr_n, n);
    chk(rd_n == (tmo ? LIMIT : busy + 1) && rd_bad == 0,
        tmo ? "R7 poll count" : (er ? "R6 poll count" : "R5 poll count"),
        rd_n, tmo ? LIMIT : busy + 1);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cycles > 190000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=<190000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(ready && !done && !err && ce_n && we_n && oe_n && !dq_oe, "R9 reset outputs",
        {ready, done, err, ce_n, we_n, oe_n, dq_oe}, 7'b1001110);
    rst_n = 1'b1;
    @(negedge clk);
    for (int d = 0; d < 256; d++) run_op(1'b0, AW'((d * 37 + 5) % 2048), 8'(d), d % LIMIT, 1'b0);
    for (int k = 0; k < 8; k++) run_op(1'b1, AW'(k * 211), 8'h00, k % LIMIT, 1'b0);
    run_op(1'b0, 11'h7FF, 8'h80, LIMIT + 3, 1'b1);
    run_op(1'b0, 11'h000, 8'h01, LIMIT, 1'b1);
    run_op(1'b1, 11'h123, 8'h00, LIMIT + 5, 1'b1);
    run_op(1'b0, 11'h555, 8'h7F, LIMIT - 1, 1'b0);
    chk(t_viol == 0, "R4 strobe timing violations", t_viol, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule